// File: doc/BRIEF.md
# Operand Mode Decoder

This block turns one 6-bit operand code of a 16-bit processor instruction into an operand description. The description says whether the operand is a register, a memory word or a short constant. It also gives the register index, the memory address or the constant value. As side effects it returns the new stack pointer and program counter, and it reports whether the operand costs an extra cycle. The caller pulses `start` with the code and the current register file, SP, PC and overflow value. It then waits for a one-cycle `done` pulse. The outputs are registered and hold their values until the next accepted `start`.

Some codes take the word stored at PC as an offset or an address. These are the indexed codes 0x10–0x17 and the absolute-address code 0x1E. For them the block issues a read on a simple memory port in the same cycle it accepts `start`. The memory returns data one cycle later, and `done` follows one cycle after that. All other codes finish with `done` one cycle after `start`. While a read is outstanding, a new `start` is ignored. All address and pointer arithmetic wraps modulo 2^16.

Kind encoding on `kind`: 0 = register, 1 = memory, 2 = literal. Register index on `reg_idx`: 0–7 = general registers, 8 = SP, 9 = PC, 10 = overflow.

Top module: `opnd_decode`

## Requirements
- R1: Codes 0x00–0x07 give kind 0, reg_idx equal to the code, val equal to that general register, sp_out/pc_out equal to sp_in/pc_in, extra_cyc 0, and done in the cycle after start.
- R2: Codes 0x08–0x0F give kind 1, addr equal to general register (code − 8), no SP/PC change, extra_cyc 0, and done in the cycle after start.
- R3: Codes 0x10–0x17 assert rd_en with rd_addr = pc_in in the start cycle. They give kind 1, addr = (word read + general register (code − 0x10)) mod 2^16, pc_out = (pc_in + 1) mod 2^16 and extra_cyc 1, with done two cycles after start.
- R4: Code 0x18 gives kind 1, addr = sp_in and sp_out = (sp_in + 1) mod 2^16.
- R5: Code 0x19 gives kind 1, addr = sp_in and sp_out = sp_in.
- R6: Code 0x1A gives kind 1 and sp_out = addr = (sp_in − 1) mod 2^16.
- R7: Codes 0x1B, 0x1C and 0x1D give kind 0 with reg_idx 8, 9 and 10, and val equal to sp_in, pc_in and ovf_in. extra_cyc is 0.
- R8: Code 0x1E asserts rd_en with rd_addr = pc_in. It gives kind 1, addr equal to the word read, pc_out = pc_in + 1 and extra_cyc 1, with done two cycles after start.
- R9: Code 0x1F gives kind 1, addr = pc_in, pc_out = pc_in + 1 and extra_cyc 1. It asserts no rd_en and gives done in the cycle after start.
- R10: Codes 0x20–0x3F give kind 2 and val = code − 0x20 (0–31). writable is 0, so the caller drops any write to this operand. Register and memory kinds give writable 1.
- R11: done is a single-cycle pulse. A start that arrives while a read is outstanding is ignored and leaves the pending result unchanged. rd_en is asserted only for codes 0x10–0x17 and 0x1E.
- R12: After reset, done, rd_en and kind are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding `code` |
| code | input | 6 | Operand code |
| gpr | input | 128 | General registers, register i in bits [16i+15:16i] |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Current program counter (next word) |
| ovf_in | input | 16 | Current overflow register |
| rd_en | output | 1 | Next-word read request |
| rd_addr | output | 16 | Next-word read address |
| rd_data | input | 16 | Read data, valid the cycle after rd_en |
| done | output | 1 | Result valid pulse |
| kind | output | 2 | 0 register, 1 memory, 2 literal |
| reg_idx | output | 4 | Register index for kind 0 |
| addr | output | 16 | Memory address for kind 1 |
| val | output | 16 | Register value or literal value |
| writable | output | 1 | Operand may be written |
| sp_out | output | 16 | Updated stack pointer |
| pc_out | output | 16 | Updated program counter |
| extra_cyc | output | 1 | Operand costs one extra cycle |

## Verification
Each operand group is driven with different register contents, so that picking the wrong register or the wrong base shows up as a wrong value. The stack codes run at SP = 0xFFFF and SP = 0. Those two values separate pop, peek and push by both the direction and the order of the pointer update, and they exercise the wrap. The next-word codes use a memory whose content is computed from the address. A wrong read address, a missing offset or a read at the wrong cycle therefore gives a different result. One case also makes the indexed sum wrap past 0xFFFF. A start held high through an outstanding read shows whether a second request can disturb the pending result.

// File: rtl/opnd_decode.sv
module opnd_decode #(
  parameter int W    = 16,
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [5:0]        code,
  input  logic [NREG*W-1:0] gpr,
  input  logic [W-1:0]      sp_in,
  input  logic [W-1:0]      pc_in,
  input  logic [W-1:0]      ovf_in,
  output logic              rd_en,
  output logic [W-1:0]      rd_addr,
  input  logic [W-1:0]      rd_data,
  output logic              done,
  output logic [1:0]        kind,
  output logic [3:0]        reg_idx,
  output logic [W-1:0]      addr,
  output logic [W-1:0]      val,
  output logic              writable,
  output logic [W-1:0]      sp_out,
  output logic [W-1:0]      pc_out,
  output logic              extra_cyc
);
  localparam logic [1:0] K_REG = 2'd0, K_MEM = 2'd1, K_LIT = 2'd2;

  logic         busy;
  logic [W-1:0] base_q;
  logic [W-1:0] gsel;
  logic         accept, needs_rd;

  assign gsel     = gpr[code[2:0]*W +: W];
  assign needs_rd = (code[5:3] == 3'b010) || (code == 6'h1e);
  assign accept   = start && !busy;
  assign rd_en    = accept && needs_rd;
  assign rd_addr  = pc_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      base_q    <= '0;
      done      <= 1'b0;
      kind      <= K_REG;
      reg_idx   <= '0;
      addr      <= '0;
      val       <= '0;
      writable  <= 1'b0;
      sp_out    <= '0;
      pc_out    <= '0;
      extra_cyc <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        busy <= 1'b0;
        done <= 1'b1;
        addr <= rd_data + base_q;
      end else if (accept) begin
        sp_out    <= sp_in;
        pc_out    <= pc_in;
        extra_cyc <= 1'b0;
        val       <= '0;
        addr      <= '0;
        reg_idx   <= '0;
        writable  <= 1'b1;
        kind      <= K_MEM;
        if (needs_rd) begin
          busy      <= 1'b1;
          base_q    <= code[4] && code[3] ? '0 : gsel;
          pc_out    <= pc_in + 1'b1;
          extra_cyc <= 1'b1;
        end else begin
          done <= 1'b1;
          if (code[5]) begin
            kind     <= K_LIT;
            val      <= {{(W-5){1'b0}}, code[4:0]};
            writable <= 1'b0;
          end else if (code[5:3] == 3'b000) begin
            kind    <= K_REG;
            reg_idx <= {1'b0, code[2:0]};
            val     <= gsel;
          end else if (code[5:3] == 3'b001) begin
            addr <= gsel;
          end else begin
            case (code[2:0])
              3'd0: begin addr <= sp_in; sp_out <= sp_in + 1'b1; end
              3'd1: addr <= sp_in;
              3'd2: begin addr <= sp_in - 1'b1; sp_out <= sp_in - 1'b1; end
              3'd3: begin kind <= K_REG; reg_idx <= 4'd8;  val <= sp_in;  end
              3'd4: begin kind <= K_REG; reg_idx <= 4'd9;  val <= pc_in;  end
              3'd5: begin kind <= K_REG; reg_idx <= 4'd10; val <= ovf_in; end
              default: begin addr <= pc_in; pc_out <= pc_in + 1'b1; extra_cyc <= 1'b1; end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/opnd_decode_chk.sv
module opnd_decode_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [5:0]   code,
  input logic [W-1:0] pc_in,
  input logic         rd_en,
  input logic [W-1:0] rd_addr,
  input logic         done,
  input logic [1:0]   kind,
  input logic         writable,
  input logic         extra_cyc
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_rd_from_pc: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr == pc_in);

  a_r11_rd_codes: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (code[5:3] == 3'b010 || code == 6'h1e));

  a_r8_rd_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !done);

  a_r10_lit_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == 2'd2) |-> !writable);

  a_r7_reg_no_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == 2'd0) |-> (!extra_cyc && writable));
endmodule

bind opnd_decode opnd_decode_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code(code), .pc_in(pc_in), .rd_en(rd_en),
  .rd_addr(rd_addr), .done(done), .kind(kind), .writable(writable),
  .extra_cyc(extra_cyc)
);

// File: tb/tb_opnd_decode.sv
module tb_opnd_decode;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rst_n = 0, start = 0;
  logic [5:0]   code = 0;
  logic [127:0] gpr = 0;
  logic [15:0]  sp_in = 0, pc_in = 0, ovf_in = 0, rd_data = 0;
  logic         rd_en, done, writable, extra_cyc;
  logic [15:0]  rd_addr, addr, val, sp_out, pc_out;
  logic [1:0]   kind;
  logic [3:0]   reg_idx;

  int n_chk = 0, n_fail = 0;

  opnd_decode dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mw(input logic [15:0] a);
    return a * 16'd3 + 16'h1234;
  endfunction

  function automatic logic [15:0] gv(input int i);
    return 16'h0101 * 16'(i + 1) + 16'h2000;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mw(rd_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [5:0] c, output int lat, output bit rd);
    @(negedge clk);
    code = c; start = 1;
    #1 rd = rd_en;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 5) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    check("R12 done", done, 0);
    check("R12 rd_en", rd_en, 0);
    check("R12 kind", kind, 0);
  endtask

  task automatic t_gpr;
    int lat; bit rd;
    for (int i = 0; i < 8; i += 7) begin
      run(6'(i), lat, rd);
      check("R1 lat", lat, 1); check("R1 rd", rd, 0);
      check("R1 kind", kind, 0); check("R1 idx", reg_idx, i);
      check("R1 val", val, gv(i)); check("R1 sp", sp_out, sp_in);
      check("R1 pc", pc_out, pc_in); check("R1 extra", extra_cyc, 0);
      check("R10 writable", writable, 1);
    end
  endtask

  task automatic t_indirect;
    int lat; bit rd;
    run(6'h0b, lat, rd);
    check("R2 lat", lat, 1); check("R2 kind", kind, 1);
    check("R2 addr", addr, gv(3)); check("R2 pc", pc_out, pc_in);
    check("R2 extra", extra_cyc, 0);
  endtask

  task automatic t_indexed;
    int lat; bit rd;
    pc_in = 16'h0040;
    run(6'h15, lat, rd);
    check("R3 rd", rd, 1); check("R3 lat", lat, 2); check("R3 kind", kind, 1);
    check("R3 addr", addr, mw(16'h0040) + gv(5));
    check("R3 pc", pc_out, 16'h0041); check("R3 extra", extra_cyc, 1);
    pc_in = 16'hffff;
    gpr[7*16 +: 16] = 16'hf000;
    run(6'h17, lat, rd);
    check("R3 wrap addr", addr, 16'(mw(16'hffff) + 16'hf000));
    check("R3 wrap pc", pc_out, 16'h0000);
    gpr[7*16 +: 16] = gv(7);
    pc_in = 16'h0100;
  endtask

  task automatic t_stack;
    int lat; bit rd;
    sp_in = 16'hffff;
    run(6'h18, lat, rd);
    check("R4 addr", addr, 16'hffff); check("R4 sp", sp_out, 16'h0000);
    check("R4 kind", kind, 1);
    run(6'h19, lat, rd);
    check("R5 addr", addr, 16'hffff); check("R5 sp", sp_out, 16'hffff);
    sp_in = 16'h0000;
    run(6'h1a, lat, rd);
    check("R6 addr", addr, 16'hffff); check("R6 sp", sp_out, 16'hffff);
    check("R6 kind", kind, 1);
    sp_in = 16'h8000;
  endtask

  task automatic t_special;
    int lat; bit rd;
    run(6'h1b, lat, rd);
    check("R7 sp idx", reg_idx, 8); check("R7 sp val", val, 16'h8000);
    check("R7 kind", kind, 0);
    run(6'h1c, lat, rd);
    check("R7 pc idx", reg_idx, 9); check("R7 pc val", val, pc_in);
    run(6'h1d, lat, rd);
    check("R7 ovf idx", reg_idx, 10); check("R7 ovf val", val, 16'hbeef);
  endtask

  task automatic t_nextword;
    int lat; bit rd;
    run(6'h1e, lat, rd);
    check("R8 rd", rd, 1); check("R8 lat", lat, 2);
    check("R8 addr", addr, mw(16'h0100)); check("R8 pc", pc_out, 16'h0101);
    check("R8 extra", extra_cyc, 1);
    run(6'h1f, lat, rd);
    check("R9 rd", rd, 0); check("R9 lat", lat, 1); check("R9 kind", kind, 1);
    check("R9 addr", addr, 16'h0100); check("R9 pc", pc_out, 16'h0101);
    check("R9 extra", extra_cyc, 1);
  endtask

  task automatic t_literal;
    int lat; bit rd;
    run(6'h20, lat, rd);
    check("R10 kind", kind, 2); check("R10 val0", val, 0);
    check("R10 writable", writable, 0); check("R10 rd", rd, 0);
    run(6'h3f, lat, rd);
    check("R10 val31", val, 31); check("R10 extra", extra_cyc, 0);
  endtask

  task automatic t_busy;
    @(negedge clk);
    code = 6'h12; start = 1;
    @(posedge clk);
    @(negedge clk);
    code = 6'h00;
    check("R11 no rd while busy", rd_en, 0);
    @(posedge clk);
    @(negedge clk);
    start = 0;
    check("R11 done", done, 1);
    check("R11 kind kept", kind, 1);
    check("R11 addr kept", addr, mw(16'h0100) + gv(2));
    @(negedge clk);
    check("R11 pulse", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) gpr[i*16 +: 16] = gv(i);
    sp_in = 16'h8000; pc_in = 16'h0100; ovf_in = 16'hbeef;
    #(CLK_PERIOD*2 + 2);
    t_reset;
    rst_n = 1;
    t_gpr;
    t_indirect;
    t_indexed;
    t_stack;
    t_special;
    t_nextword;
    t_literal;
    t_busy;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule